// File: doc/BRIEF.md
# Per-Source Interrupt Trigger Detector

This block keeps one pending flag for each interrupt source line, up to 256 of them. Every source has a two-bit sense code. The code selects whether the flag mirrors the line level, or is raised by a falling transition, a rising transition or any transition. A flag raised by a transition stays up until software writes it to zero or the processor acknowledges that source. A flag in level mode cannot be cleared that way, because it always mirrors its line.

A contiguous group of sources, 32 of them starting at source 64, is wired to external pins. Each of these has a byte-wide mode register that software can read and write, with the sense code in bits 3:2. The sense codes of all other sources are fixed when the block comes out of reset. The outputs are the pending vector and a per-source indication of level mode. Arbitration among the pending sources belongs to a downstream priority stage.

Top module: `irq_trigger_detect`

## Requirements
- R1: Sense codes are 0 = level, 1 = falling edge, 2 = rising edge, 3 = both edges. `lvl_mode_o[i]` is 1 exactly when source i holds code 0.
- R2: In level mode, `pend_o[i]` after a clock edge equals the value `src_in[i]` had just before that edge, whatever writes or acknowledges occur.
- R3: In an edge mode, a flag is set at a clock edge where `src_in[i]` differs from its value one cycle earlier in the selected direction. It then stays set until it is cleared.
- R4: A flag-register write (`cfg_sel`=0) whose `cfg_wdata` bit 0 is 0 clears the addressed edge-mode flag at that edge. A write with bit 0 = 1 has no effect. In level mode such writes are ignored.
- R5: `ack_valid` with `ack_id` = i clears flag i at that edge when source i is in an edge mode. In level mode it has no effect.
- R6: When a qualifying transition and a clear (write or acknowledge) hit the same source at the same edge, the flag ends up set.
- R7: Mode register k (`cfg_sel`=1, k in 0..31) holds the code of source 64+k in bits 3:2. A write updates only that field. Reads return the field with all other bits 0. Indexes 32 and above are ignored on write and read as 0.
- R8: Reset (synchronous, active low) clears every flag. It loads code 2 into every source, except those set in the `LVL_INIT` parameter, which get code 0. A line already high while reset is asserted produces no edge when reset is released.
- R9: A flag-register read (`cfg_sel`=0) returns the addressed flag in bit 0 and zero in bits 7:1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_in | input | NUM_SRC | Source request lines, synchronous to clk |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | Register space: 0 = flag registers, 1 = mode registers |
| cfg_idx | input | IDX_W | Register index within the selected space |
| cfg_wdata | input | 8 | Write data byte |
| cfg_rdata | output | 8 | Read data byte for the addressed register |
| ack_valid | input | 1 | Processor acknowledge strobe |
| ack_id | input | IDX_W | Source being acknowledged |
| pend_o | output | NUM_SRC | Pending flag per source |
| lvl_mode_o | output | NUM_SRC | 1 where the source is in level mode |

## Verification
Random line activity runs against all 256 sources at once while random flag writes, mode writes and acknowledges target a small cluster of pin and non-pin sources. These cases separate the four sense codes, and they show whether clears are refused in level mode. Directed sequences cover cases that random stimulus seldom hits in isolation. These include a transition that coincides with a clear, a write of 1 to a flag, a mode write beyond the pin group, and a line that is high through reset, which must not register as a rising edge.

// File: rtl/irq_trig_pkg.sv
// Shared definitions for the per-source trigger detector.
package irq_trig_pkg;
    typedef enum logic [1:0] {
        SENSE_LEVEL = 2'd0,
        SENSE_FALL  = 2'd1,
        SENSE_RISE  = 2'd2,
        SENSE_BOTH  = 2'd3
    } sense_t;

    localparam int BYTE_W   = 8;
    localparam int MODE_LSB = 2;
endpackage

// File: rtl/irq_trig_cell.sv
// One source: previous-level register, transition detect and pending flag.
// Assumes din is synchronous to clk. The previous-level register is not
// reset, so a line held steady through reset shows no transition afterwards.
module irq_trig_cell
    import irq_trig_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       din,
    input  logic [1:0] mode,
    input  logic       sw_clr,
    input  logic       ack_clr,
    output logic       flag_o
);
    logic prev_q;
    logic flag_q;
    logic evt;
    logic lvl;
    logic clr;

    assign lvl = (mode == SENSE_LEVEL);
    assign clr = sw_clr | ack_clr;

    // Track the line every cycle, reset included.
    always_ff @(posedge clk) begin
        prev_q <= din;
    end

    // Select which transition counts for this source.
    always_comb begin
        unique case (mode)
            SENSE_FALL: evt = prev_q & ~din;
            SENSE_RISE: evt = ~prev_q & din;
            SENSE_BOTH: evt = prev_q ^ din;
            default:    evt = 1'b0;
        endcase
    end

    // Pending flag: mirror in level mode, set-dominant latch in edge modes.
    always_ff @(posedge clk) begin
        if (!rst_n)      flag_q <= 1'b0;
        else if (lvl)    flag_q <= din;
        else if (evt)    flag_q <= 1'b1;
        else if (clr)    flag_q <= 1'b0;
    end

    assign flag_o = flag_q;

    // R2
    lvl_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lvl |=> (flag_q == $past(din)));
    // R3
    edge_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!lvl && evt) |=> flag_q);
    // R3
    edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!lvl && flag_q && !clr) |=> flag_q);
    // R4 R5
    edge_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!lvl && clr && !evt) |=> !flag_q);
endmodule

// File: rtl/irq_mode_bank.sv
// Sense code storage. Pin sources hold a writable code; all others keep
// their reset default as a constant. Assumes PIN_BASE+PIN_CNT <= NUM_SRC.
module irq_mode_bank
    import irq_trig_pkg::*;
#(
    parameter int                   NUM_SRC  = 256,
    parameter int                   PIN_BASE = 64,
    parameter int                   PIN_CNT  = 32,
    parameter int                   IDX_W    = 8,
    parameter logic [NUM_SRC-1:0]   LVL_INIT = '0
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [IDX_W-1:0]          wr_idx,
    input  logic [1:0]                wr_code,
    output logic [NUM_SRC-1:0][1:0]   mode_vec
);
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        localparam logic [1:0] INIT = LVL_INIT[i] ? SENSE_LEVEL : SENSE_RISE;
        if (i >= PIN_BASE && i < PIN_BASE + PIN_CNT) begin : g_pin
            logic [1:0] code_q;
            // Load the code from a mode-register write aimed at this pin.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    code_q <= INIT;
                else if (wr_en && wr_idx == IDX_W'(i - PIN_BASE))
                    code_q <= wr_code;
            end
            assign mode_vec[i] = code_q;
        end else begin : g_fixed
            assign mode_vec[i] = INIT;
        end
    end

    logic [PIN_CNT-1:0][1:0] pin_codes;
    assign pin_codes = mode_vec[PIN_BASE +: PIN_CNT];

    // R7
    oob_mode_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx >= IDX_W'(PIN_CNT)) |=> $stable(pin_codes));
endmodule

// File: rtl/irq_read_mux.sv
// Read data for the flag and mode register spaces. Purely combinational.
module irq_read_mux
    import irq_trig_pkg::*;
#(
    parameter int NUM_SRC  = 256,
    parameter int PIN_BASE = 64,
    parameter int PIN_CNT  = 32,
    parameter int IDX_W    = 8
) (
    input  logic                     sel_mode,
    input  logic [IDX_W-1:0]         idx,
    input  logic [NUM_SRC-1:0]       flags,
    input  logic [NUM_SRC-1:0][1:0]  mode_vec,
    output logic [BYTE_W-1:0]        rdata
);
    localparam int PIN_W = (PIN_CNT > 1) ? $clog2(PIN_CNT) : 1;

    logic [PIN_CNT-1:0][1:0] pin_codes;
    assign pin_codes = mode_vec[PIN_BASE +: PIN_CNT];

    // Pick the byte for the addressed register.
    always_comb begin
        rdata = '0;
        if (sel_mode) begin
            if (idx < IDX_W'(PIN_CNT))
                rdata[MODE_LSB +: 2] = pin_codes[idx[PIN_W-1:0]];
        end else if (32'(idx) < NUM_SRC) begin
            rdata[0] = flags[idx];
        end
    end
endmodule

// File: rtl/irq_trigger_detect.sv
// Top: register decode, per-source cells, mode storage and read mux.
// Assumes all inputs are synchronous to clk; one register access per cycle.
module irq_trigger_detect
    import irq_trig_pkg::*;
#(
    parameter int                 NUM_SRC  = 256,
    parameter int                 PIN_BASE = 64,
    parameter int                 PIN_CNT  = 32,
    parameter int                 IDX_W    = $clog2(NUM_SRC),
    parameter logic [NUM_SRC-1:0] LVL_INIT = (NUM_SRC'(1) << 5) | (NUM_SRC'(1) << 70)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_in,
    input  logic               cfg_we,
    input  logic               cfg_sel,
    input  logic [IDX_W-1:0]   cfg_idx,
    input  logic [7:0]         cfg_wdata,
    output logic [7:0]         cfg_rdata,
    input  logic               ack_valid,
    input  logic [IDX_W-1:0]   ack_id,
    output logic [NUM_SRC-1:0] pend_o,
    output logic [NUM_SRC-1:0] lvl_mode_o
);
    logic [NUM_SRC-1:0][1:0] mode_vec;
    logic                    flag_wr;
    logic                    mode_wr;
    logic                    unused_wbits;

    assign flag_wr      = cfg_we && !cfg_sel;
    assign mode_wr      = cfg_we && cfg_sel;
    assign unused_wbits = ^{cfg_wdata[7:4], cfg_wdata[1]};

    irq_mode_bank #(
        .NUM_SRC (NUM_SRC),
        .PIN_BASE(PIN_BASE),
        .PIN_CNT (PIN_CNT),
        .IDX_W   (IDX_W),
        .LVL_INIT(LVL_INIT)
    ) i_modes (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (mode_wr),
        .wr_idx  (cfg_idx),
        .wr_code (cfg_wdata[MODE_LSB +: 2]),
        .mode_vec(mode_vec)
    );

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_cell
        logic sw_clr;
        logic ack_clr;
        assign sw_clr  = flag_wr && (cfg_idx == IDX_W'(i)) && !cfg_wdata[0];
        assign ack_clr = ack_valid && (ack_id == IDX_W'(i));
        assign lvl_mode_o[i] = (mode_vec[i] == SENSE_LEVEL);

        irq_trig_cell i_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .din    (src_in[i]),
            .mode   (mode_vec[i]),
            .sw_clr (sw_clr),
            .ack_clr(ack_clr),
            .flag_o (pend_o[i])
        );
    end

    irq_read_mux #(
        .NUM_SRC (NUM_SRC),
        .PIN_BASE(PIN_BASE),
        .PIN_CNT (PIN_CNT),
        .IDX_W   (IDX_W)
    ) i_rd (
        .sel_mode(cfg_sel),
        .idx     (cfg_idx),
        .flags   (pend_o),
        .mode_vec(mode_vec),
        .rdata   (cfg_rdata)
    );

    // R8
    rst_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (pend_o == '0));
endmodule

// File: tb/test_irq_trigger_detect.sv
`timescale 1ns/1ps
module test_irq_trigger_detect;
    localparam int N  = 256;
    localparam int PB = 64;
    localparam int PC = 32;
    localparam int IW = 8;
    localparam logic [N-1:0] LVL = (N'(1) << 5) | (N'(1) << 70);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  src_in = '0;
    logic          cfg_we = 1'b0;
    logic          cfg_sel = 1'b0;
    logic [IW-1:0] cfg_idx = '0;
    logic [7:0]    cfg_wdata = '0;
    logic [7:0]    cfg_rdata;
    logic          ack_valid = 1'b0;
    logic [IW-1:0] ack_id = '0;
    logic [N-1:0]  pend_o;
    logic [N-1:0]  lvl_mode_o;

    int  n_run  = 0;
    int  n_fail = 0;
    bit  done   = 0;

    logic [1:0]   m_mode [N];
    logic [N-1:0] m_flag;
    logic [N-1:0] m_prev;

    always #4 clk = ~clk;

    irq_trigger_detect #(.NUM_SRC(N), .PIN_BASE(PB), .PIN_CNT(PC), .IDX_W(IW), .LVL_INIT(LVL))
    i_irq_trigger_detect (
        .clk(clk), .rst_n(rst_n), .src_in(src_in),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .ack_valid(ack_valid), .ack_id(ack_id),
        .pend_o(pend_o), .lvl_mode_o(lvl_mode_o)
    );

    task automatic chk(string tag, logic [N-1:0] act, logic [N-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic exp_evt(logic [1:0] md, logic d, logic p);
        case (md)
            2'd1:    return p & ~d;
            2'd2:    return ~p & d;
            2'd3:    return p ^ d;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [N-1:0] exp_lvl();
        logic [N-1:0] v;
        for (int i = 0; i < N; i++) v[i] = (m_mode[i] == 2'd0);
        return v;
    endfunction

    function automatic logic [7:0] exp_rd(logic sel, logic [IW-1:0] idx);
        if (!sel) return {7'b0, m_flag[idx]};
        if (idx < PC) return {4'b0, m_mode[PB + idx], 2'b00};
        return 8'h00;
    endfunction

    // Reference update for one clock edge using the values currently driven.
    task automatic model_edge();
        logic [N-1:0] nf;
        for (int i = 0; i < N; i++) begin
            logic clr;
            clr = (cfg_we && !cfg_sel && cfg_idx == IW'(i) && !cfg_wdata[0]) ||
                  (ack_valid && ack_id == IW'(i));
            if (m_mode[i] == 2'd0)                          nf[i] = src_in[i];
            else if (exp_evt(m_mode[i], src_in[i], m_prev[i])) nf[i] = 1'b1;
            else if (clr)                                   nf[i] = 1'b0;
            else                                            nf[i] = m_flag[i];
        end
        m_flag = nf;
        m_prev = src_in;
        if (cfg_we && cfg_sel && cfg_idx < PC) m_mode[PB + cfg_idx] = cfg_wdata[3:2];
    endtask

    // Starts and ends at a falling edge.
    task automatic step(string tag, logic [N-1:0] din, logic we, logic sel,
                        logic [IW-1:0] idx, logic [7:0] wd, logic av, logic [IW-1:0] aid);
        src_in = din; cfg_we = we; cfg_sel = sel; cfg_idx = idx;
        cfg_wdata = wd; ack_valid = av; ack_id = aid;
        #1;
        if (!we) chk({tag, " R9 R7 rdata"}, N'(cfg_rdata), N'(exp_rd(sel, idx)));
        @(posedge clk);
        model_edge();
        @(negedge clk);
        chk({tag, " pend"}, pend_o, m_flag);
        chk({tag, " R1 lvl"}, lvl_mode_o, exp_lvl());
    endtask

    function automatic logic [N-1:0] rnd_vec();
        logic [N-1:0] v;
        for (int k = 0; k < N / 32; k++) v[k*32 +: 32] = $urandom;
        return v;
    endfunction

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog act=hung exp=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] cur;
        void'($urandom(32'd20240611));
        // R8: lines high through reset
        src_in = '1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R8 reset pend", pend_o, '0);
        chk("R8 reset lvl", lvl_mode_o, LVL);
        cfg_sel = 1'b1; cfg_idx = 8'd6; #1;
        chk("R8 reset mode 70", N'(cfg_rdata), N'(8'h00));
        cfg_idx = 8'd0; #1;
        chk("R8 reset mode 64", N'(cfg_rdata), N'(8'h08));
        for (int i = 0; i < N; i++) m_mode[i] = LVL[i] ? 2'd0 : 2'd2;
        m_flag = '0;
        m_prev = '1;
        rst_n = 1'b1;
        cur = '1;
        step("R8 no edge after reset", cur, 0, 0, 8'd64, 8'h00, 0, 8'd0);
        chk("R8 only level flags", pend_o, LVL);
        // R7: falling mode for pin 64, junk bits ignored
        step("R7 wr", cur, 1, 1, 8'd0, 8'hF7, 0, 8'd0);
        step("R7 rd", cur, 0, 1, 8'd0, 8'h00, 0, 8'd0);
        cur[64] = 1'b0;
        step("R3 fall set", cur, 0, 0, 8'd64, 8'h00, 0, 8'd0);
        step("R3 hold", cur, 0, 0, 8'd64, 8'h00, 0, 8'd0);
        step("R4 write1 ignored", cur, 1, 0, 8'd64, 8'h01, 0, 8'd0);
        step("R4 read", cur, 0, 0, 8'd64, 8'h00, 0, 8'd0);
        step("R4 write0 clears", cur, 1, 0, 8'd64, 8'hFE, 0, 8'd0);
        cur[64] = 1'b1;
        step("R3 rise no set", cur, 0, 0, 8'd64, 8'h00, 0, 8'd0);
        cur[64] = 1'b0;
        step("R6 edge beats clear", cur, 1, 0, 8'd64, 8'h00, 1, 8'd64);
        chk("R6 flag64", N'(pend_o[64]), N'(1'b1));
        step("R5 ack clears", cur, 0, 0, 8'd64, 8'h00, 1, 8'd64);
        chk("R5 flag64", N'(pend_o[64]), N'(1'b0));
        step("R5 ack level ignored", cur, 0, 0, 8'd5, 8'h00, 1, 8'd5);
        step("R4 write0 level ignored", cur, 1, 0, 8'd5, 8'h00, 0, 8'd0);
        chk("R4 flag5", N'(pend_o[5]), N'(1'b1));
        cur[5] = 1'b0;
        step("R2 level drop", cur, 0, 0, 8'd5, 8'h00, 0, 8'd0);
        step("R7 oob write", cur, 1, 1, 8'd40, 8'h00, 0, 8'd0);
        step("R7 oob read", cur, 0, 1, 8'd40, 8'h00, 0, 8'd0);
        step("R1 both", cur, 1, 1, 8'd2, 8'h0C, 0, 8'd0);
        step("R1 level", cur, 1, 1, 8'd3, 8'h00, 0, 8'd0);
        cur[66] = 1'b0;
        step("R1 both fall", cur, 0, 1, 8'd2, 8'h00, 0, 8'd0);
        // Random phase: R1 R2 R3 R4 R5 R6 R7 R9
        for (int n = 0; n < 6000; n++) begin
            logic [IW-1:0] idx;
            logic [IW-1:0] aid;
            int op;
            cur = cur ^ (rnd_vec() & rnd_vec());
            op  = $urandom % 8;
            idx = ($urandom % 2) ? IW'(64 + $urandom % 8) : IW'($urandom % 8);
            aid = ($urandom % 2) ? IW'(64 + $urandom % 8) : IW'($urandom % 8);
            if (op < 2)
                step("rnd R4", cur, 1, 0, idx, 8'($urandom), $urandom % 2, aid);
            else if (op == 2)
                step("rnd R7", cur, 1, 1, IW'($urandom % 40), 8'($urandom), $urandom % 2, aid);
            else
                step("rnd R2 R3 R5", cur, 0, $urandom % 2,
                     ($urandom % 2) ? idx : IW'($urandom % 40), 8'h00, $urandom % 2, aid);
        end
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule